// File: doc/BRIEF.md
# Out-of-Frame SPI Sensor Target

This block is the device side of a 32-bit SPI link in which every answer travels one frame late. The host shifts in a request frame while the target shifts out its answer to the previous request. At the end of each frame the target checks the 3-bit CRC of the request. A good write updates a small bank of control registers. A good read looks up a register and holds the answer for the next frame. A failed check produces an error answer instead.

Sensor values for temperature, three acceleration axes and three rotation-rate axes come in on ports. A read request can carry a capture flag. That flag copies all seven live values into snapshot registers in one clock, so that later reads of the snapshot range return one coherent sample set. The SPI pins are sampled in the system clock domain. SCLK idles low, data is taken on the rising SCLK edge and MISO changes after the falling edge.

Top module: `oof_spi_target`

## Requirements
- R1: After reset, spi_miso and ctl_o are 0. The answer shifted out in the first frame has data 0, bits 31 and 3 clear, and a valid CRC.
- R2: The CRC covers a 32-bit word MSB first, starts from 3'b101 and feeds back with polynomial 3'b011. A request is accepted only if the CRC over all 32 of its bits is zero. Every answer carries in bits 2:0 the CRC of its bits 31:3 with the low bits taken as zero, so the CRC over the whole answer is zero.
- R3: The answer to the request of frame N is shifted out MSB first on spi_miso during frame N+1, never during frame N.
- R4: The read address sits in request bits 29:22 and the answer data in bits 19:4. Address 0x00 returns 0x0024. Address 0x10 returns temperature, 0x11..0x13 acceleration X/Y/Z, 0x14..0x16 rate X/Y/Z, 0x17..0x1D the snapshot of the same seven channels in the same order, and 0x0A..0x0B the control registers. Every other address returns 0.
- R5: A request with bit 21 set is a write. Bits 18:3 are stored into the control register named by bits 29:22, and ctl_o[16k+15:16k] shows control register k at 0x0A+k. The answer to a write carries the written data.
- R6: A read request with bit 20 set copies all seven live channels into the snapshot registers in one clock. A snapshot address read by that same request returns the freshly captured value.
- R7: Snapshot registers keep their value while the live inputs change, until the next capture request.
- R8: A request whose CRC check fails is not executed. The next answer has bits 31 and 3 both set and data 0. Answers to good requests have both of these bits clear.
- R9: A frame that ends with a bit count other than 32 is dropped. No register changes, and the next frame repeats the answer that was pending before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low, marks one frame |
| spi_mosi | input | 1 | Request data from host, MSB first |
| spi_miso | output | 1 | Answer data to host, MSB first |
| temp_i | input | 16 | Live temperature sample |
| accel_i | input | 48 | Live acceleration, X in bits 15:0, Y 31:16, Z 47:32 |
| rate_i | input | 48 | Live rotation rate, X in bits 15:0, Y 31:16, Z 47:32 |
| ctl_o | output | 32 | Control registers, register 0 in bits 15:0 |

## Verification
Pin changes reach the core after the two-flop synchronizers and one more edge-detect flop. The bench therefore holds each SCLK level for six system clocks and reads MISO just before it raises SCLK, by which time the falling-edge shift has settled. Register writes, snapshots and the pending answer update in the clock after chip-select release is detected. Control-register checks are made eight clocks after chip select rises. Every read answer is checked in the frame that follows its request, which is the one-frame lag the block defines.

// File: rtl/oofs_pkg.sv
package oofs_pkg;
  localparam int FRM_W     = 32;
  localparam int DAT_W     = 16;
  localparam int ADR_W     = 8;
  localparam logic [2:0] CRC_SEED = 3'b101;
  localparam logic [2:0] CRC_TAPS = 3'b011;
  localparam int ERR_HI    = 31;
  localparam int ERR_LO    = 3;
  localparam int DATA_LSB  = 4;
  localparam int WDATA_LSB = 3;
  localparam int WR_BIT    = 21;
  localparam int CAP_BIT   = 20;
  localparam int ADDR_LSB  = 22;

  // serial 3-bit CRC over a full frame, MSB first
  function automatic logic [2:0] crc3(input logic [FRM_W-1:0] w);
    logic [2:0] c;
    logic fb;
    c = CRC_SEED;
    for (int i = FRM_W - 1; i >= 0; i--) begin
      fb = c[2];
      c  = {c[1:0], w[i]};
      if (fb) c = c ^ CRC_TAPS;
    end
    return c;
  endfunction

  // answer word: status bits, data field, CRC in the low three bits
  function automatic logic [FRM_W-1:0] make_resp(input logic [DAT_W-1:0] d,
                                                 input logic err);
    logic [FRM_W-1:0] w;
    w = '0;
    w[ERR_HI] = err;
    w[ERR_LO] = err;
    w[DATA_LSB +: DAT_W] = d;
    w[2:0] = crc3(w);
    return w;
  endfunction
endpackage

// File: rtl/oofs_sync.sv
module oofs_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/oofs_shift.sv
module oofs_shift #(
  parameter int FW    = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             active_i,
  input  logic             sample_i,
  input  logic             shift_i,
  input  logic             mosi_i,
  input  logic [FW-1:0]    load_i,
  output logic [FW-1:0]    rx_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             miso_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FW + 1);

  logic [FW-1:0] tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_o  <= '0;
      cnt_o <= '0;
    end else if (start_i) begin
      tx_q  <= load_i;
      rx_o  <= '0;
      cnt_o <= '0;
    end else if (active_i) begin
      if (sample_i) begin
        rx_o <= {rx_o[FW-2:0], mosi_i};
        if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
      end
      if (shift_i) tx_q <= {tx_q[FW-2:0], 1'b0};
    end
  end

  assign miso_o = tx_q[FW-1];
endmodule

// File: rtl/oofs_regs.sv
module oofs_regs #(
  parameter int NCH   = 7,
  parameter int DW    = 16,
  parameter int AW    = 8,
  parameter int CTL_N = 2,
  parameter logic [AW-1:0] ID_ADDR   = 8'h00,
  parameter logic [DW-1:0] ID_VAL    = 16'h0024,
  parameter logic [AW-1:0] LIVE_BASE = 8'h10,
  parameter logic [AW-1:0] CAP_BASE  = 8'h17,
  parameter logic [AW-1:0] CTL_BASE  = 8'h0A
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic                cap_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [NCH*DW-1:0]   live_i,
  output logic [DW-1:0]       rdata_o,
  output logic [NCH*DW-1:0]   snap_o,
  output logic [CTL_N*DW-1:0] ctl_o
);
  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_snap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     snap_o[g*DW +: DW] <= '0;
        else if (cap_i) snap_o[g*DW +: DW] <= live_i[g*DW +: DW];
      end
    end
    for (g = 0; g < CTL_N; g++) begin : g_ctl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_o[g*DW +: DW] <= '0;
        else if (wr_i && addr_i == AW'(CTL_BASE + g)) ctl_o[g*DW +: DW] <= wdata_i;
      end
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (addr_i == ID_ADDR) rdata_o = ID_VAL;
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == AW'(LIVE_BASE + c)) rdata_o = live_i[c*DW +: DW];
      if (addr_i == AW'(CAP_BASE + c))
        rdata_o = cap_i ? live_i[c*DW +: DW] : snap_o[c*DW +: DW];
    end
    for (int k = 0; k < CTL_N; k++)
      if (addr_i == AW'(CTL_BASE + k)) rdata_o = ctl_o[k*DW +: DW];
  end
endmodule

// File: rtl/oof_spi_target.sv
module oof_spi_target
  import oofs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int AXES        = 3,
  parameter int CTL_N       = 2,
  parameter logic [ADR_W-1:0] ID_ADDR   = 8'h00,
  parameter logic [DAT_W-1:0] ID_VAL    = 16'h0024,
  parameter logic [ADR_W-1:0] LIVE_BASE = 8'h10,
  parameter logic [ADR_W-1:0] CAP_BASE  = 8'h17,
  parameter logic [ADR_W-1:0] CTL_BASE  = 8'h0A
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     spi_sclk,
  input  logic                     spi_cs_n,
  input  logic                     spi_mosi,
  output logic                     spi_miso,
  input  logic [DAT_W-1:0]         temp_i,
  input  logic [AXES*DAT_W-1:0]    accel_i,
  input  logic [AXES*DAT_W-1:0]    rate_i,
  output logic [CTL_N*DAT_W-1:0]   ctl_o
);
  localparam int NCH   = 1 + 2 * AXES;
  localparam int CNT_W = $clog2(FRM_W + 2);

  // pin synchronizers: {mosi, cs_n, sclk}
  logic [2:0] pins_s;
  logic sclk_s, cs_s, mosi_s, sclk_q, cs_q;

  oofs_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({spi_mosi, spi_cs_n, spi_sclk}),
    .sync_o (pins_s)
  );

  assign sclk_s = pins_s[0];
  assign cs_s   = pins_s[1];
  assign mosi_s = pins_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
    end
  end

  // named events
  logic frame_start, frame_end, sclk_rise, sclk_fall;
  assign frame_start = ~cs_s & cs_q;
  assign frame_end   = cs_s & ~cs_q;
  assign sclk_rise   = ~cs_s & sclk_s & ~sclk_q;
  assign sclk_fall   = ~cs_s & ~sclk_s & sclk_q;

  logic [FRM_W-1:0] req_w, pend_q, pend_next;
  logic [CNT_W-1:0] bit_cnt;

  oofs_shift #(.FW(FRM_W), .CNT_W(CNT_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (frame_start),
    .active_i(~cs_s),
    .sample_i(sclk_rise),
    .shift_i (sclk_fall),
    .mosi_i  (mosi_s),
    .load_i  (pend_q),
    .rx_o    (req_w),
    .cnt_o   (bit_cnt),
    .miso_o  (spi_miso)
  );

  // request decode
  logic frame_full, crc_ok, exec_ok, wr_exec, cap_exec, req_wr;
  logic [ADR_W-1:0] req_addr;
  logic [DAT_W-1:0] req_wdata, rd_data;

  assign frame_full = (bit_cnt == CNT_W'(FRM_W));
  assign crc_ok     = (crc3(req_w) == 3'd0);
  assign req_wr     = req_w[WR_BIT];
  assign req_addr   = req_w[ADDR_LSB +: ADR_W];
  assign req_wdata  = req_w[WDATA_LSB +: DAT_W];
  assign exec_ok    = frame_end & frame_full & crc_ok;
  assign wr_exec    = exec_ok & req_wr;
  assign cap_exec   = exec_ok & ~req_wr & req_w[CAP_BIT];

  logic [NCH*DAT_W-1:0] live_w, snap_w;
  assign live_w = {rate_i, accel_i, temp_i};

  oofs_regs #(
    .NCH(NCH), .DW(DAT_W), .AW(ADR_W), .CTL_N(CTL_N),
    .ID_ADDR(ID_ADDR), .ID_VAL(ID_VAL), .LIVE_BASE(LIVE_BASE),
    .CAP_BASE(CAP_BASE), .CTL_BASE(CTL_BASE)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (wr_exec),
    .cap_i  (cap_exec),
    .addr_i (req_addr),
    .wdata_i(req_wdata),
    .live_i (live_w),
    .rdata_o(rd_data),
    .snap_o (snap_w),
    .ctl_o  (ctl_o)
  );

  // answer for the next frame
  always_comb begin
    pend_next = pend_q;
    if (frame_end && frame_full) begin
      if (!crc_ok)     pend_next = make_resp('0, 1'b1);
      else if (req_wr) pend_next = make_resp(req_wdata, 1'b0);
      else             pend_next = make_resp(rd_data, 1'b0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= make_resp('0, 1'b0);
    else        pend_q <= pend_next;
  end
endmodule

// File: rtl/oofs_chk.sv
module oofs_chk
  import oofs_pkg::*;
#(
  parameter int NCH   = 7,
  parameter int CTL_N = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     frame_end,
  input logic                     frame_full,
  input logic                     crc_ok,
  input logic                     cap_exec,
  input logic                     cs_s,
  input logic                     miso,
  input logic [FRM_W-1:0]         pend_q,
  input logic [NCH*DAT_W-1:0]     live_w,
  input logic [NCH*DAT_W-1:0]     snap_w,
  input logic [CTL_N*DAT_W-1:0]   ctl_o
);
  // R2
  pend_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc3(pend_q) == 3'd0);

  // R8
  bad_req_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && frame_full && !crc_ok) |=> (pend_q[ERR_HI] && pend_q[ERR_LO]));

  // R8
  bad_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !crc_ok) |=> $stable(ctl_o));

  // R9
  short_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_full) |=> ($stable(pend_q) && $stable(ctl_o) && $stable(snap_w)));

  // R6
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_exec |=> (snap_w == $past(live_w)));

  // R7
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_exec |=> $stable(snap_w));

  // R3
  idle_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> $stable(miso));
endmodule

bind oof_spi_target oofs_chk #(.NCH(NCH), .CTL_N(CTL_N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_end (frame_end),
  .frame_full(frame_full),
  .crc_ok    (crc_ok),
  .cap_exec  (cap_exec),
  .cs_s      (cs_s),
  .miso      (spi_miso),
  .pend_q    (pend_q),
  .live_w    (live_w),
  .snap_w    (snap_w),
  .ctl_o     (ctl_o)
);

// File: tb/tb_oof_spi_target.sv
module tb_oof_spi_target;
  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, mosi;
  logic miso;
  logic [15:0] temp;
  logic [47:0] accel, rate;
  logic [31:0] ctl;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  oof_spi_target dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .temp_i(temp), .accel_i(accel),
    .rate_i(rate), .ctl_o(ctl)
  );

  // CRC written as explicit next-state equations (seed 101, taps 011)
  function automatic logic [2:0] tb_crc(input logic [31:0] w);
    logic [2:0] c;
    logic fb;
    c = 3'b101;
    for (int i = 31; i >= 0; i--) begin
      fb = c[2];
      c = {c[1], c[0] ^ fb, w[i] ^ fb};
    end
    return c;
  endfunction

  function automatic logic [31:0] mk_req(input logic wr, input logic cap,
                                         input logic [7:0] addr, input logic [15:0] d);
    logic [31:0] w;
    w = {2'b00, addr, wr, cap, 1'b0, d, 3'b000};
    w[2:0] = tb_crc(w);
    return w;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic spi_frame(input logic [31:0] tx, input int nbits, output logic [31:0] rx);
    rx = '0;
    cs_n = 1'b0;
    wait_clk(6);
    for (int b = 0; b < nbits; b++) begin
      mosi = tx[31 - b];
      wait_clk(6);
      rx = {rx[30:0], miso};
      sclk = 1'b1;
      wait_clk(6);
      sclk = 1'b0;
    end
    wait_clk(6);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic check_resp(input string tag, input logic [31:0] rx,
                            input logic [15:0] exp_d, input logic exp_err);
    check_eq({tag, " data"}, {16'h0, rx[19:4]}, {16'h0, exp_d});
    check_eq({tag, " status"}, {30'h0, rx[31], rx[3]}, {30'h0, exp_err, exp_err});
    check_eq({tag, " R2 crc"}, {29'h0, tb_crc(rx)}, 32'h0);
  endtask

  // {wr, cap, addr[7:0], wdata[15:0], expected answer data[15:0]}
  localparam int NV = 6;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 16'h0000, 16'h0024},
    {1'b0, 1'b0, 8'h12, 16'h0000, 16'h0202},
    {1'b1, 1'b0, 8'h0A, 16'hBEEF, 16'hBEEF},
    {1'b0, 1'b0, 8'h0A, 16'h0000, 16'hBEEF},
    {1'b0, 1'b0, 8'h16, 16'h0000, 16'h3333},
    {1'b0, 1'b0, 8'h40, 16'h0000, 16'h0000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rx;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    temp = 16'h1234;
    accel = {16'h0303, 16'h0202, 16'h0101};
    rate  = {16'h3333, 16'h2222, 16'h1111};
    wait_clk(5);
    // R1 reset state
    check_eq("R1 miso in reset", {31'h0, miso}, 32'h0);
    check_eq("R1 ctl in reset", ctl, 32'h0);
    rst_n = 1'b1;
    wait_clk(5);

    // vector table: answer to entry i arrives in frame i+1 (R3)
    for (int i = 0; i < NV; i++) begin
      spi_frame(mk_req(VEC[i][41], VEC[i][40], VEC[i][39:32], VEC[i][31:16]), 32, rx);
      if (i == 0) check_resp("R1 first answer", rx, 16'h0000, 1'b0);
      else        check_resp("R3 R4 R5 vector", rx, VEC[i-1][15:0], 1'b0);
    end
    spi_frame(mk_req(1'b0, 1'b0, 8'h00, 16'h0), 32, rx);
    check_resp("R4 unmapped", rx, VEC[NV-1][15:0], 1'b0);
    check_eq("R5 ctl reg0 written", ctl, 32'h0000BEEF);

    // capture: R6 and R7
    temp = 16'h0AAA;
    rate[47:32] = 16'h7777;
    spi_frame(mk_req(1'b0, 1'b1, 8'h17, 16'h0), 32, rx);
    temp = 16'h0BBB;
    rate[47:32] = 16'h6666;
    spi_frame(mk_req(1'b0, 1'b0, 8'h1D, 16'h0), 32, rx);
    check_resp("R6 fresh capture read", rx, 16'h0AAA, 1'b0);
    spi_frame(mk_req(1'b0, 1'b0, 8'h17, 16'h0), 32, rx);
    check_resp("R6 rate z snapped", rx, 16'h7777, 1'b0);
    spi_frame(mk_req(1'b0, 1'b0, 8'h10, 16'h0), 32, rx);
    check_resp("R7 snapshot held", rx, 16'h0AAA, 1'b0);
    spi_frame(mk_req(1'b0, 1'b0, 8'h00, 16'h0), 32, rx);
    check_resp("R4 live temp", rx, 16'h0BBB, 1'b0);

    // bad CRC: R8
    spi_frame(mk_req(1'b1, 1'b0, 8'h0A, 16'h1111) ^ 32'h1, 32, rx);
    check_eq("R8 bad write ignored", ctl, 32'h0000BEEF);
    spi_frame(mk_req(1'b0, 1'b0, 8'h0A, 16'h0), 32, rx);
    check_resp("R8 error answer", rx, 16'h0000, 1'b1);
    spi_frame(mk_req(1'b0, 1'b0, 8'h00, 16'h0), 32, rx);
    check_resp("R8 reg kept", rx, 16'hBEEF, 1'b0);

    // short frame: R9
    spi_frame(mk_req(1'b0, 1'b0, 8'h11, 16'h0), 32, rx);
    check_resp("R9 setup", rx, 16'h0024, 1'b0);
    spi_frame(mk_req(1'b1, 1'b0, 8'h0B, 16'h5555), 16, rx);
    check_eq("R9 short frame no write", ctl, 32'h0000BEEF);
    spi_frame(mk_req(1'b0, 1'b0, 8'h00, 16'h0), 32, rx);
    check_resp("R9 pending repeated", rx, 16'h0101, 1'b0);

    // second control register: R5
    spi_frame(mk_req(1'b1, 1'b0, 8'h0B, 16'hA5A5), 32, rx);
    check_eq("R5 ctl reg1 written", ctl, 32'hA5A5BEEF);
    spi_frame(mk_req(1'b0, 1'b0, 8'h00, 16'h0), 32, rx);
    check_resp("R5 write echo", rx, 16'hA5A5, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule